// File: doc/BRIEF.md
# Retained-RAM Sleep and Restart Sequencer

This block decides when a small processor core sleeps and when it may run again. While the core runs, a one-cycle power-off request from the core parks the block in a back-up state. The oscillator enable drops, the core is held in reset, and a sticky power-down flag is set. RAM and most core registers keep their contents because nothing is clocked.

Two things end the back-up state. A level on the wake input gives a warm start, and the flag stays set. Any of the reset sources gives a cold start, and the flag is cleared. The reset sources are power-on, watchdog and supply-drop. Whichever path ends back-up, the oscillator is re-enabled and the block counts a fixed number of oscillator edges before it releases the core. In the last held cycle, the block strobes the program-counter-to-zero load. On a warm start it also strobes the stack-pointer preset, with the preset value driven on its own port. Software reads the flag through a query input to choose between its warm and cold start paths.

Top module: `lpm_seq_top`

## Requirements
- R1: When `pof_i` is high at a rising `clk_i` edge while the core runs, then after that edge `osc_en_o` is 0, `cpu_rst_n_o` is 0 and `pflag_o` is 1. No further `clk_i` edges occur while the oscillator is off.
- R2: While any bit of `rst_src_i` is 1, the following hold at once, without a clock edge: `pflag_o` is 0, `osc_en_o` is 1 and `cpu_rst_n_o` is 0. Bit 0 is power-on reset, bit 1 is watchdog reset and bit 2 is supply-drop reset, all active high.
- R3: A high `wake_i` in back-up sets `osc_en_o` to 1 at once and keeps `cpu_rst_n_o` at 0. `pflag_o` stays 1 (warm start).
- R4: After a wake from back-up, or after the last reset source is released, `cpu_rst_n_o` rises at exactly the 16384th rising `clk_i` edge.
- R5: `pc_init_o` is 1 for exactly one `clk_i` cycle on every start, warm or cold. That cycle is the one just before `cpu_rst_n_o` rises.
- R6: `sp_init_o` is 1 in that same cycle only on a warm start (`pflag_o` = 1). It never pulses on a cold start. `sp_init_val_o` is binary 11.
- R7: `skip_o` equals `qry_i` AND `pflag_o`.
- R8: If a reset source and `wake_i` rise together during back-up, the start is cold: `pflag_o` becomes 0 and no `sp_init_o` pulse occurs.
- R9: A reset source asserted during stabilization clears `pflag_o`. The count restarts, so release comes 16384 edges after the reset is released.
- R10: `pof_i` during stabilization is ignored: `osc_en_o` stays 1 and the core stays held.
- R11: `wake_i` while the core runs is ignored: `osc_en_o`, `cpu_rst_n_o` and `pflag_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; runs only while `osc_en_o` is high |
| rst_src_i | input | N_RST | Reset sources, active high (bit 0 power-on, bit 1 watchdog, bit 2 supply-drop) |
| wake_i | input | 1 | External wake level, acted on only in back-up |
| pof_i | input | 1 | Power-off request from the core, one cycle |
| qry_i | input | 1 | Flag query from the core |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_rst_n_o | output | 1 | Core reset, active low |
| pc_init_o | output | 1 | Load program counter with address zero |
| sp_init_o | output | 1 | Preset stack pointer (warm start only) |
| sp_init_val_o | output | SP_W | Stack pointer preset value |
| pflag_o | output | 1 | Power-down flag |
| skip_o | output | 1 | Query answer: flag set |

## Verification
Two events can fall in the same instant: a wake and a reset that both end back-up. The bench raises a reset source and `wake_i` in one statement while the clock is stopped. It then requires a cleared flag straight away and a full 16384-edge wait. No stack-pointer strobe may appear before release. A reset that lands in the middle of a wake-started count is also provoked. The bench judges it by the flag clearing and by the release coming a full count after the reset is released.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_BACKUP = 2'd1,
    ST_STAB   = 2'd2
  } lpm_state_e;

  // true when the stabilization count has reached its final value
  function automatic logic stab_is_last(input int unsigned count, input int unsigned total);
    return (count + 1) == total;
  endfunction

  // the counter value after one oscillator edge of stabilization
  function automatic int unsigned stab_next(input int unsigned count);
    return count + 1;
  endfunction

endpackage

// File: rtl/lpm_seq_rst_merge.sv
module lpm_seq_rst_merge #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] src_i,
  output logic             any_o
);

  logic [N_SRC:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | src_i[g];
  end

  assign any_o = chain[N_SRC];

endmodule

// File: rtl/lpm_seq_pflag.sv
module lpm_seq_pflag (
  input  logic clk_i,
  input  logic clr_i,
  input  logic set_i,
  output logic flag_o
);

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i)      flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  // R1: the flag may only rise on an accepted power-off request
  assert_flag_rise_source_R1: assert property (@(posedge clk_i) disable iff (clr_i)
    $rose(flag_o) |-> $past(set_i));

  // R1: an accepted request leaves the flag set
  assert_flag_set_R1: assert property (@(posedge clk_i) disable iff (clr_i)
    set_i |=> flag_o);

endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
  import lpm_seq_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 16384
) (
  input  logic       clk_i,
  input  logic       rst_any_i,
  input  logic       wake_i,
  input  logic       pof_i,
  output lpm_state_e state_o,
  output logic       pof_accept_o,
  output logic       stab_last_o
);

  localparam int unsigned CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;

  lpm_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wake_arm;
  logic             cnt_last;

  // wake only matters while parked; the clock is stopped there
  assign wake_arm     = wake_i & (state_q == ST_BACKUP);
  assign cnt_last     = stab_is_last(32'(cnt_q), STAB_CYCLES);
  assign stab_last_o  = (state_q == ST_STAB) & cnt_last;
  assign pof_accept_o = (state_q == ST_RUN) & pof_i;
  assign state_o      = state_q;

  always_ff @(posedge clk_i or posedge rst_any_i or posedge wake_arm) begin
    if (rst_any_i) begin
      state_q <= ST_STAB;
      cnt_q   <= '0;
    end else if (wake_arm) begin
      state_q <= ST_STAB;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (pof_i) state_q <= ST_BACKUP;
        end
        ST_STAB: begin
          if (cnt_last) state_q <= ST_RUN;
          else          cnt_q   <= CNT_W'(stab_next(32'(cnt_q)));
        end
        default: begin
          state_q <= state_q;
        end
      endcase
    end
  end

  // R4: every held cycle advances the count by one
  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (rst_any_i)
    (state_q == ST_STAB && !cnt_last) |=> (state_q == ST_STAB && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R4: the final count hands over to the running core
  assert_release_R4: assert property (@(posedge clk_i) disable iff (rst_any_i)
    stab_last_o |=> (state_q == ST_RUN));

  // R10: a power-off request during stabilization never parks the block
  assert_pof_ignored_R10: assert property (@(posedge clk_i) disable iff (rst_any_i)
    (state_q == ST_STAB && pof_i) |=> (state_q != ST_BACKUP));

endmodule

// File: rtl/lpm_seq_top.sv
module lpm_seq_top
  import lpm_seq_pkg::*;
#(
  parameter int unsigned     STAB_CYCLES = 16384,
  parameter int unsigned     N_RST       = 3,
  parameter int unsigned     SP_W        = 2,
  parameter logic [SP_W-1:0] SP_INIT     = 2'b11
) (
  input  logic             clk_i,
  input  logic [N_RST-1:0] rst_src_i,
  input  logic             wake_i,
  input  logic             pof_i,
  input  logic             qry_i,
  output logic             osc_en_o,
  output logic             cpu_rst_n_o,
  output logic             pc_init_o,
  output logic             sp_init_o,
  output logic [SP_W-1:0]  sp_init_val_o,
  output logic             pflag_o,
  output logic             skip_o
);

  logic       rst_any;
  lpm_state_e state;
  logic       pof_accept;
  logic       stab_last;

  lpm_seq_rst_merge #(.N_SRC(N_RST)) u_merge (
    .src_i (rst_src_i),
    .any_o (rst_any)
  );

  lpm_seq_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
    .clk_i        (clk_i),
    .rst_any_i    (rst_any),
    .wake_i       (wake_i),
    .pof_i        (pof_i),
    .state_o      (state),
    .pof_accept_o (pof_accept),
    .stab_last_o  (stab_last)
  );

  lpm_seq_pflag u_pflag (
    .clk_i  (clk_i),
    .clr_i  (rst_any),
    .set_i  (pof_accept),
    .flag_o (pflag_o)
  );

  assign osc_en_o      = (state != ST_BACKUP);
  assign cpu_rst_n_o   = (state == ST_RUN);
  assign pc_init_o     = stab_last;
  assign sp_init_o     = stab_last & pflag_o;
  assign sp_init_val_o = SP_INIT;
  assign skip_o        = qry_i & pflag_o;

  // R5: the address-zero load is followed by a running core
  assert_pc_strobe_R5: assert property (@(posedge clk_i) disable iff (rst_any)
    pc_init_o |=> (cpu_rst_n_o && !pc_init_o));

  // R6: the stack preset comes only with a warm start's address-zero load
  assert_sp_warm_R6: assert property (@(posedge clk_i) disable iff (rst_any)
    sp_init_o |-> (pflag_o && pc_init_o && !cpu_rst_n_o));

  // R11: a running core stays running unless it asked to stop
  assert_run_holds_R11: assert property (@(posedge clk_i) disable iff (rst_any)
    (cpu_rst_n_o && !pof_i) |=> cpu_rst_n_o);

endmodule

// File: tb/lpm_seq_top_test.sv
`timescale 1ns/1ps
module lpm_seq_top_test;

  localparam int STAB = 16384;

  logic       raw = 1'b0;
  logic       en_s = 1'b0;
  logic       clk;
  logic [2:0] rst_src;
  logic       wake = 1'b0;
  logic       pof = 1'b0;
  logic       qry = 1'b0;
  logic       osc_en_o, cpu_rst_n_o, pc_init_o, sp_init_o, pflag_o, skip_o;
  logic [1:0] sp_init_val_o;

  int checks = 0;
  int failures = 0;
  int edge_cnt = 0;
  int pc_seen = 0;
  int sp_seen = 0;
  int last_spv = 0;
  int e0 = 0;
  bit done = 0;

  // oscillator model: 200 MHz, gated glitch-free by the enable
  always #2.5 raw = ~raw;
  always @(negedge raw) en_s <= osc_en_o;
  assign clk = raw & en_s;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // strobe monitors, sampled mid-cycle
  always @(negedge raw) begin
    if (pc_init_o === 1'b1) pc_seen <= pc_seen + 1;
    if (sp_init_o === 1'b1) begin
      sp_seen  <= sp_seen + 1;
      last_spv <= int'(sp_init_val_o);
    end
  end

  lpm_seq_top uut (
    .clk_i         (clk),
    .rst_src_i     (rst_src),
    .wake_i        (wake),
    .pof_i         (pof),
    .qry_i         (qry),
    .osc_en_o      (osc_en_o),
    .cpu_rst_n_o   (cpu_rst_n_o),
    .pc_init_o     (pc_init_o),
    .sp_init_o     (sp_init_o),
    .sp_init_val_o (sp_init_val_o),
    .pflag_o       (pflag_o),
    .skip_o        (skip_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_count();
    e0 = edge_cnt;
    pc_seen = 0;
    sp_seen = 0;
    last_spv = 0;
  endtask

  task automatic finish_count(output int n);
    @(posedge cpu_rst_n_o);
    #1;
    n = edge_cnt - e0;
  endtask

  task automatic power_off();
    @(negedge raw) pof = 1'b1;
    @(posedge raw);
    #1 pof = 1'b0;
  endtask

  task automatic t_cold_boot();
    int n;
    #20;
    chk(cpu_rst_n_o == 1'b0, "R2 core held in reset", int'(cpu_rst_n_o), 0);
    chk(osc_en_o == 1'b1, "R2 oscillator on in reset", int'(osc_en_o), 1);
    chk(pflag_o == 1'b0, "R2 flag cleared by reset", int'(pflag_o), 0);
    qry = 1'b1;
    #1 chk(skip_o == 1'b0, "R7 query with flag clear", int'(skip_o), 0);
    qry = 1'b0;
    @(negedge raw) rst_src = 3'b000;
    start_count();
    finish_count(n);
    chk(n == STAB, "R4 cold release edge count", n, STAB);
    chk(pc_seen == 1, "R5 pc strobe on cold start", pc_seen, 1);
    chk(sp_seen == 0, "R6 no sp strobe on cold start", sp_seen, 0);
  endtask

  task automatic t_wake_in_run();
    @(negedge raw) wake = 1'b1;
    repeat (3) @(posedge raw);
    #1;
    chk(cpu_rst_n_o == 1'b1, "R11 core keeps running", int'(cpu_rst_n_o), 1);
    chk(osc_en_o == 1'b1, "R11 oscillator stays on", int'(osc_en_o), 1);
    chk(pflag_o == 1'b0, "R11 flag unchanged", int'(pflag_o), 0);
    wake = 1'b0;
  endtask

  task automatic t_power_off();
    int e1;
    power_off();
    chk(osc_en_o == 1'b0, "R1 oscillator off", int'(osc_en_o), 0);
    chk(cpu_rst_n_o == 1'b0, "R1 core held", int'(cpu_rst_n_o), 0);
    chk(pflag_o == 1'b1, "R1 flag set", int'(pflag_o), 1);
    e1 = edge_cnt;
    #200;
    chk(edge_cnt == e1, "R1 clock stopped", edge_cnt - e1, 0);
    qry = 1'b1;
    #1 chk(skip_o == 1'b1, "R7 query with flag set", int'(skip_o), 1);
    qry = 1'b0;
  endtask

  task automatic t_warm_wake();
    int n;
    #3;
    start_count();
    wake = 1'b1;
    #1;
    chk(osc_en_o == 1'b1, "R3 oscillator restarted", int'(osc_en_o), 1);
    chk(cpu_rst_n_o == 1'b0, "R3 core still held", int'(cpu_rst_n_o), 0);
    chk(pflag_o == 1'b1, "R3 flag kept on wake", int'(pflag_o), 1);
    finish_count(n);
    wake = 1'b0;
    chk(n == STAB, "R4 warm release edge count", n, STAB);
    chk(pc_seen == 1, "R5 pc strobe on warm start", pc_seen, 1);
    chk(sp_seen == 1, "R6 sp strobe on warm start", sp_seen, 1);
    chk(last_spv == 3, "R6 sp preset value", last_spv, 3);
    chk(pflag_o == 1'b1, "R3 flag after warm release", int'(pflag_o), 1);
  endtask

  task automatic t_reset_in_stab();
    int n;
    power_off();
    #7;
    wake = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge raw) pof = 1'b1;
    @(posedge raw);
    #1 pof = 1'b0;
    chk(osc_en_o == 1'b1, "R10 pof ignored in stabilization", int'(osc_en_o), 1);
    chk(cpu_rst_n_o == 1'b0, "R10 core still held", int'(cpu_rst_n_o), 0);
    repeat (4900) @(posedge clk);
    @(negedge raw) begin
      rst_src = 3'b010;
      wake = 1'b0;
    end
    #1 chk(pflag_o == 1'b0, "R9 reset clears flag mid-count", int'(pflag_o), 1'b0);
    #20;
    @(negedge raw) rst_src = 3'b000;
    start_count();
    finish_count(n);
    chk(n == STAB, "R9 count restarted after reset", n, STAB);
    chk(sp_seen == 0, "R9 start treated as cold", sp_seen, 0);
  endtask

  task automatic t_reset_wake_tie();
    int n;
    power_off();
    chk(pflag_o == 1'b1, "R8 flag set before tie", int'(pflag_o), 1);
    #9;
    rst_src = 3'b100;
    wake = 1'b1;
    #1;
    chk(pflag_o == 1'b0, "R8 reset wins over wake", int'(pflag_o), 0);
    chk(osc_en_o == 1'b1, "R8 oscillator restarted", int'(osc_en_o), 1);
    #20;
    @(negedge raw) rst_src = 3'b000;
    start_count();
    finish_count(n);
    wake = 1'b0;
    chk(n == STAB, "R8 full wait after tie", n, STAB);
    chk(sp_seen == 0, "R8 no sp strobe after tie", sp_seen, 0);
  endtask

  initial begin
    rst_src = 3'b001;
    t_cold_boot();
    t_wake_in_run();
    t_power_off();
    t_warm_wake();
    t_reset_in_stab();
    t_reset_wake_tie();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", edge_cnt, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule